// File: doc/BRIEF.md
# Boot-time serial configuration writer

This block is a host-side master that loads a fixed set of configuration words into a receiver front end that is programmed over a three-wire latched-register port. The port has three lines: a serial clock, serial data, and a load strobe. After reset is released, or on a start pulse, the block sends eight 32-bit words in a fixed order. It shifts each word out most significant bit first. It then pulses the load strobe, which commits the word in the slave. The slave picks the destination register from the two least significant bits of each word.

All slave timing minimums are parameters given in nanoseconds, together with the system clock period in picoseconds. The block converts each minimum to system clock cycles by rounding up. The serial clock and the load strobe idle low. The busy and done outputs tell the surrounding logic when the front end is ready.

Top module: `cfg_boot_writer`

## Requirements
- R1: The words are sent in this order: 0x00000003, 0x00020406, 0x20001499, 0x40001499, 0x60001499, 0x80001499, 0xA0000019, 0x80007CA0. After the last word, the block stops.
- R2: Each word is sent as exactly 32 rising edges of `ser_clk_o`, most significant bit first. `ser_data_o` is sampled on each rising edge. One high pulse on `ser_le_o` follows the 32 edges.
- R3: `ser_data_o` holds its value for at least the data setup count of cycles before every rising edge of `ser_clk_o`.
- R4: `ser_data_o` changes only while `ser_clk_o` is low. A change comes at least the data hold count of cycles after the preceding rising edge.
- R5: Every high phase of `ser_clk_o` lasts at least the clock-high count of cycles. Every low phase before a rising edge lasts at least the clock-low count.
- R6: `ser_le_o` rises at least the clock-to-strobe count of cycles after the last rising edge of a word. It stays high for at least the strobe-width count. It has been low for at least the strobe-setup count before the first rising edge of the next word.
- R7: During reset and whenever the block is idle, `ser_clk_o`, `ser_le_o`, `busy_o` and `done_o` are low. `ser_data_o` is low during reset.
- R8: `busy_o` rises in the cycle after a run is accepted. It falls in the cycle in which the final strobe falls. `done_o` is high for exactly that one cycle.
- R9: With `AUTO_RUN` set, a run starts by itself on the first clock edge after reset is released. A reset in the middle of a run abandons the run, and the block starts again from the first word.
- R10: A `start_i` pulse while busy has no effect on the serial outputs or on busy and done. A `start_i` pulse while idle runs the whole sequence again.
- R11: Each cycle count is the nanosecond minimum times 1000, divided by `SYS_PERIOD_PS`, rounded up, and at least 1. High phases last max(clock-high, data-hold) cycles. Low phases last max(clock-low, data-setup) cycles, or for the first bit of a word max(clock-low, data-setup, strobe-setup) cycles. The gap and the strobe use their own counts. At the 8000 ps default, the high phase is exactly 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | Request a run; honoured only while idle |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when the final strobe falls |
| ser_clk_o | output | 1 | Serial clock to the slave, idles low |
| ser_data_o | output | 1 | Serial data to the slave, MSB first |
| ser_le_o | output | 1 | Load strobe to the slave, idles low |

## Verification
The bench goes after the seams between words. There, a design that reused the ordinary low length for the first bit would squeeze the strobe-to-clock setup. A design that let the strobe follow the last clock too closely would break the clock-to-strobe gap. Both show up in the receiver's edge-by-edge cycle counts and as mismatches against the cycle-exact expected waveform.

The bench pulses start in the middle of a run. A design that restarted would shift a second copy of the first word and break the waveform comparison. The bench also resets the block mid-word. A design that resumed rather than restarted would deliver a truncated or out-of-order word, and a design that skipped the auto-run would leave busy low.

An off-by-one in the nanosecond-to-cycle rounding shows up as a wrong exact high-phase length.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  localparam int unsigned BOOT_WORDS = 8;
  localparam int unsigned WORD_BITS  = 32;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_GAP,
    PH_LATCH
  } phase_e;

  // ceil(ns * 1000 / period_ps), never below one cycle
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // fixed boot sequence; order matters to the slave
  function automatic logic [31:0] boot_word(int unsigned k);
    case (k)
      0:       return 32'h0000_0003;
      1:       return 32'h0002_0406;
      2:       return 32'h2000_1499;
      3:       return 32'h4000_1499;
      4:       return 32'h6000_1499;
      5:       return 32'h8000_1499;
      6:       return 32'hA000_0019;
      7:       return 32'h8000_7CA0;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_word_rom.sv
module cfg_word_rom
  import cfg_boot_pkg::*;
#(
  parameter int unsigned N_WORDS = BOOT_WORDS,
  parameter int unsigned AW      = $clog2(N_WORDS)
) (
  input  logic [AW-1:0]          addr_i,
  output logic [WORD_BITS-1:0]   word_o
);

  always_comb word_o = boot_word(int'(addr_i));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl #(
  parameter int unsigned N_WORDS  = 8,
  parameter bit          AUTO_RUN = 1'b1,
  parameter int unsigned AW       = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic          word_end_i,
  output logic          go_o,
  output logic          more_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);

  logic          busy_q, done_q, pend_q;
  logic [AW-1:0] idx_q;
  logic          last_w;

  assign last_w = (idx_q == LAST_IDX);
  assign go_o   = !busy_q && (start_i || pend_q);
  assign more_o = !last_w;
  // next word must be on the table output at the edge the timer reloads
  assign addr_o = go_o ? '0 : (word_end_i ? idx_q + 1'b1 : idx_q);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= AUTO_RUN;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_o) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        idx_q  <= '0;
      end else if (busy_q && word_end_i) begin
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R8: done coincides with the end of busy
  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10: start while busy does not end or restart the run
  p_busy_ignores_start_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && start_i && !word_end_i) |=> busy_o);

endmodule

// File: rtl/cfg_serial_timer.sv
module cfg_serial_timer
  import cfg_boot_pkg::*;
#(
  parameter int unsigned LOW_CYC       = 4,
  parameter int unsigned FIRST_LOW_CYC = 4,
  parameter int unsigned HIGH_CYC      = 4,
  parameter int unsigned GAP_CYC       = 2,
  parameter int unsigned LATCH_CYC     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 go_i,
  input  logic                 more_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic                 ser_clk_o,
  output logic                 ser_data_o,
  output logic                 ser_le_o,
  output logic                 word_end_o
);

  localparam int unsigned MAXLEN = max_of(max_of(LOW_CYC, FIRST_LOW_CYC),
                                          max_of(HIGH_CYC, max_of(GAP_CYC, LATCH_CYC)));
  localparam int unsigned CW = $clog2(MAXLEN + 1);
  localparam int unsigned BW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] FIRST_LD = CW'(FIRST_LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] LATCH_LD = CW'(LATCH_CYC - 1);

  phase_e                 ph_q;
  logic [CW-1:0]          cnt_q;
  logic [BW-1:0]          bit_q;
  logic [WORD_BITS-1:0]   sh_q;
  logic                   dat_q;
  logic                   tick_w;

  assign tick_w     = (cnt_q == '0);
  assign ser_clk_o  = (ph_q == PH_HIGH);
  assign ser_le_o   = (ph_q == PH_LATCH);
  assign ser_data_o = dat_q;
  assign word_end_o = (ph_q == PH_LATCH) && tick_w;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      dat_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= FIRST_LD;
          bit_q <= BW'(WORD_BITS - 1);
          dat_q <= word_i[WORD_BITS-1];
          sh_q  <= word_i << 1;
        end
        PH_LOW: if (tick_w) begin
          ph_q  <= PH_HIGH;
          cnt_q <= HIGH_LD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HIGH: if (tick_w) begin
          if (bit_q == '0) begin
            ph_q  <= PH_GAP;
            cnt_q <= GAP_LD;
          end else begin
            ph_q  <= PH_LOW;
            cnt_q <= LOW_LD;
            bit_q <= bit_q - 1'b1;
            dat_q <= sh_q[WORD_BITS-1];
            sh_q  <= sh_q << 1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_GAP: if (tick_w) begin
          ph_q  <= PH_LATCH;
          cnt_q <= LATCH_LD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_LATCH: if (tick_w) begin
          if (more_i) begin
            ph_q  <= PH_LOW;
            cnt_q <= FIRST_LD;
            bit_q <= BW'(WORD_BITS - 1);
            dat_q <= word_i[WORD_BITS-1];
            sh_q  <= word_i << 1;
          end else ph_q <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // observation counters for the assertions below
  logic        clk_d;
  logic [31:0] lvl_n;
  logic [31:0] rise_n;
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      clk_d  <= 1'b0;
      lvl_n  <= '0;
      rise_n <= '0;
    end else begin
      clk_d  <= ser_clk_o;
      lvl_n  <= (ser_clk_o != clk_d) ? 32'd1 :
                ((lvl_n == 32'hFFFF_FFFF) ? lvl_n : lvl_n + 32'd1);
      rise_n <= ser_le_o ? 32'd0 :
                ((ser_clk_o && !clk_d) ? rise_n + 32'd1 : rise_n);
    end
  end

  // R4: data moves only while the serial clock is low
  p_data_moves_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(ser_data_o) |-> !ser_clk_o);
  // R5: high phase length
  p_high_len_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(ser_clk_o) |-> (lvl_n >= HIGH_CYC));
  // R5: low phase length
  p_low_len_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ser_clk_o) |-> (lvl_n >= LOW_CYC));
  // R2: strobe only after a full word of edges
  p_full_word_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ser_le_o) |-> (rise_n == WORD_BITS));
  // R6: strobe and clock never high together
  p_le_clk_apart_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ser_le_o && ser_clk_o));

endmodule

// File: rtl/cfg_boot_writer.sv
module cfg_boot_writer
  import cfg_boot_pkg::*;
#(
  parameter int unsigned SYS_PERIOD_PS  = 8000,
  parameter int unsigned T_DSETUP_NS    = 10,
  parameter int unsigned T_DHOLD_NS     = 10,
  parameter int unsigned T_CLKHI_NS     = 25,
  parameter int unsigned T_CLKLO_NS     = 25,
  parameter int unsigned T_LESETUP_NS   = 20,
  parameter int unsigned T_CLK2LE_NS    = 10,
  parameter int unsigned T_LEWIDTH_NS   = 20,
  parameter bit          AUTO_RUN       = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ser_clk_o,
  output logic ser_data_o,
  output logic ser_le_o
);

  localparam int unsigned C_DSU  = ns_to_cycles(T_DSETUP_NS,  SYS_PERIOD_PS);
  localparam int unsigned C_DH   = ns_to_cycles(T_DHOLD_NS,   SYS_PERIOD_PS);
  localparam int unsigned C_HI   = ns_to_cycles(T_CLKHI_NS,   SYS_PERIOD_PS);
  localparam int unsigned C_LO   = ns_to_cycles(T_CLKLO_NS,   SYS_PERIOD_PS);
  localparam int unsigned C_LESU = ns_to_cycles(T_LESETUP_NS, SYS_PERIOD_PS);
  localparam int unsigned C_GAP  = ns_to_cycles(T_CLK2LE_NS,  SYS_PERIOD_PS);
  localparam int unsigned C_LEW  = ns_to_cycles(T_LEWIDTH_NS, SYS_PERIOD_PS);
  localparam int unsigned HIGH_LEN  = max_of(C_HI, C_DH);
  localparam int unsigned LOW_LEN   = max_of(C_LO, C_DSU);
  localparam int unsigned FIRST_LEN = max_of(LOW_LEN, C_LESU);
  localparam int unsigned AW = $clog2(BOOT_WORDS);

  logic                 go_w, more_w, word_end_w;
  logic [AW-1:0]        addr_w;
  logic [WORD_BITS-1:0] word_w;

  cfg_seq_ctrl #(.N_WORDS(BOOT_WORDS), .AUTO_RUN(AUTO_RUN), .AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .word_end_i (word_end_w),
    .go_o       (go_w),
    .more_o     (more_w),
    .addr_o     (addr_w),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  cfg_word_rom #(.N_WORDS(BOOT_WORDS), .AW(AW)) u_rom (
    .addr_i (addr_w),
    .word_o (word_w)
  );

  cfg_serial_timer #(
    .LOW_CYC       (LOW_LEN),
    .FIRST_LOW_CYC (FIRST_LEN),
    .HIGH_CYC      (HIGH_LEN),
    .GAP_CYC       (C_GAP),
    .LATCH_CYC     (C_LEW)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .go_i       (go_w),
    .more_i     (more_w),
    .word_i     (word_w),
    .ser_clk_o  (ser_clk_o),
    .ser_data_o (ser_data_o),
    .ser_le_o   (ser_le_o),
    .word_end_o (word_end_w)
  );

  // R7: quiet serial lines whenever no run is active
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (!ser_clk_o && !ser_le_o));
  // R8: busy drops only together with done
  p_busy_fall_done_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/sim_cfg_boot_writer.sv
`timescale 1ns/1ps
module sim_cfg_boot_writer;

  logic clk = 1'b0;
  logic rst, start;
  logic busy, done, sclk, sdata, sle;

  always #4 clk = ~clk;  // 125 MHz

  cfg_boot_writer u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .busy_o(busy), .done_o(done),
    .ser_clk_o(sclk), .ser_data_o(sdata), .ser_le_o(sle)
  );

  logic [31:0] exp_words [8] = '{32'h00000003, 32'h00020406, 32'h20001499, 32'h40001499,
                                 32'h60001499, 32'h80001499, 32'hA0000019, 32'h80007CA0};

  int n_chk = 0, n_fail = 0, cyc = 0;
  int DSU, DH, CH, CL, LESU, C2LE, LEW, HI, LO, LOF;

  // R11: cycles are the smallest count covering the nanosecond minimum
  function automatic int to_cyc(int ns);
    int n = 0;
    while (n * 8000 < ns * 1000) n++;
    if (n < 1) n = 1;
    return n;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected per-cycle {busy, done, clk, le, data}
  logic [4:0] model[$];

  int rx_k, bitcnt, clk_run, data_age, since_rise, since_lefall, le_run;
  logic p_clk, p_le, p_data;
  logic [31:0] shreg;
  bit seen_high;

  task automatic build_model();
    model.delete();
    rx_k = 0;
    for (int w = 0; w < 8; w++) begin
      for (int b = 31; b >= 0; b--) begin
        int lo_n = (b == 31) ? LOF : LO;
        for (int i = 0; i < lo_n; i++) model.push_back({1'b1, 1'b0, 1'b0, 1'b0, exp_words[w][b]});
        for (int i = 0; i < HI; i++)   model.push_back({1'b1, 1'b0, 1'b1, 1'b0, exp_words[w][b]});
      end
      for (int i = 0; i < C2LE; i++) model.push_back({1'b1, 1'b0, 1'b0, 1'b0, exp_words[w][0]});
      for (int i = 0; i < LEW; i++)  model.push_back({1'b1, 1'b0, 1'b0, 1'b1, exp_words[w][0]});
    end
    model.push_back({1'b0, 1'b1, 1'b0, 1'b0, exp_words[7][0]});
  endtask

  task automatic rx_reset();
    bitcnt = 0; clk_run = 1000; data_age = 1000; since_rise = 1000;
    since_lefall = 1000; le_run = 1000; p_clk = 1'b0; p_le = 1'b0; p_data = 1'b0;
    shreg = '0;
  endtask

  always @(negedge clk) begin
    logic [4:0] got, e;
    got = {busy, done, sclk, sle, sdata};
    if (rst) begin
      chk(got == 5'b0, "R7 reset state", int'(got), 0);
      rx_reset();
    end else begin
      if (model.size() > 0) begin
        e = model.pop_front();
        if (got[4:3] != e[4:3]) chk(1'b0, "R8 busy/done vs model", int'(got), int'(e));
        else chk(got[2:0] == e[2:0], "R2 serial lines vs model", int'(got), int'(e));
      end else begin
        chk(got[4:1] == 4'b0, "R7 idle lines", int'(got[4:1]), 0);
      end
      // behavioural serial receiver
      if (sclk && !p_clk) begin
        chk(clk_run >= CL, "R5 clk low time", clk_run, CL);
        chk(data_age >= DSU, "R3 data setup", data_age, DSU);
        if (bitcnt == 0) chk(since_lefall >= LESU, "R6 strobe to first clk", since_lefall, LESU);
        shreg = {shreg[30:0], sdata};
        bitcnt++;
        since_rise = 0;
        clk_run = 0;
      end
      if (!sclk && p_clk) begin
        chk(clk_run >= CH, "R5 clk high time", clk_run, CH);
        if (!seen_high) begin
          chk(clk_run == HI, "R11 exact high length", clk_run, HI);
          seen_high = 1'b1;
        end
        clk_run = 0;
      end
      if (sdata != p_data) begin
        chk(!sclk, "R4 data moved while clk high", int'(sclk), 0);
        chk(since_rise >= DH, "R4 data hold", since_rise, DH);
        data_age = 0;
      end
      if (sle && !p_le) begin
        chk(bitcnt == 32, "R2 edges per word", bitcnt, 32);
        chk(since_rise >= C2LE, "R6 clk to strobe", since_rise, C2LE);
        chk(shreg == exp_words[rx_k % 8], "R1 word value", int'(shreg), int'(exp_words[rx_k % 8]));
        rx_k++;
        le_run = 0;
      end
      if (!sle && p_le) begin
        chk(le_run >= LEW, "R6 strobe width", le_run, LEW);
        bitcnt = 0;
        since_lefall = 0;
      end
      if (clk_run < 100000) clk_run++;
      if (data_age < 100000) data_age++;
      if (since_rise < 100000) since_rise++;
      if (since_lefall < 100000) since_lefall++;
      if (le_run < 100000) le_run++;
      p_clk = sclk; p_le = sle; p_data = sdata;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic drain();
    while (model.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    DSU = to_cyc(10); DH = to_cyc(10); CH = to_cyc(25); CL = to_cyc(25);
    LESU = to_cyc(20); C2LE = to_cyc(10); LEW = to_cyc(20);
    HI = (CH > DH) ? CH : DH;
    LO = (CL > DSU) ? CL : DSU;
    LOF = (LO > LESU) ? LO : LESU;
    seen_high = 1'b0;
    rx_reset();
    rx_k = 0;
    rst = 1'b1; start = 1'b0;
    repeat (4) @(negedge clk);     // R7 reset state sampled by the monitor
    #1 rst = 1'b0;                 // R9 auto run after release
    build_model();
    repeat (700) @(negedge clk);
    #1 start = 1'b1;               // R10 start while busy is ignored
    @(negedge clk); #1 start = 1'b0;
    drain();
    chk(rx_k == 8, "R1 words in auto run", rx_k, 8);

    @(negedge clk); #1 start = 1'b1;   // R10 start while idle reruns
    build_model();
    @(negedge clk); #1 start = 1'b0;
    drain();
    chk(rx_k == 8, "R10 words in started run", rx_k, 8);

    @(negedge clk); #1 start = 1'b1;   // R9 reset mid-word abandons the run
    build_model();
    @(negedge clk); #1 start = 1'b0;
    repeat (330) @(negedge clk);
    #1 rst = 1'b1;
    model.delete();
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    build_model();
    drain();
    chk(rx_k == 8, "R9 words after mid-run reset", rx_k, 8);
    chk(!busy && !done, "R8 quiet after finish", int'({busy, done}), 0);
    finish_run();
  end

endmodule